// File: doc/BRIEF.md
# Periodic Tick Timer with Selectable Count Rate

This block is a 24-bit down-counting timer that gives software a steady periodic event. Software writes a reload value, clears the running count, and turns the counter on. From then on the counter steps down once per tick. When it passes from 1 to 0 it sets a sticky wrap flag and, if enabled, pulses its interrupt line. On the tick after it reaches 0 it loads the reload value again, so one period is reload + 1 ticks.

The tick is either every core clock cycle or a one-cycle enable that a free-running prescaler produces every eighth core clock. One control bit chooses the source, and after reset it selects the slow rate. The same reload value therefore gives a period eight times longer when the slow source is in use.

The counter is reached through a plain register port. It has a 2-bit register select, separate write and read strobes, 32-bit write data and a combinational read data bus.

Top module: `tick_timer_top`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low. Control bit 2 reads 0, so the divided tick is selected.
- R2: Select 0 is control/status: bit 0 run enable, bit 1 interrupt enable, bit 2 rate select (1 = every core clock, 0 = every eighth clock), bit 16 wrap flag (read only). Select 1 is the 24-bit reload value. Select 2 is the current count. Select 3 reads 0 and ignores writes. Unused upper bits read 0.
- R3: With rate select 1 and the counter running, successive interrupts are exactly reload + 1 core clocks apart.
- R4: With rate select 0, the counter steps only on a prescaler pulse that occurs once every 8 core clocks. Successive interrupts are 8 × (reload + 1) core clocks apart.
- R5: On each tick the count decreases by one. A tick that finds the count at 0 loads the reload value instead.
- R6: A tick that moves the count from 1 to 0 sets the wrap flag. It also drives `irq_o` high for exactly one core clock, in the cycle where the flag first reads 1, but only when the interrupt enable is set.
- R7: A read strobe on select 0 returns the flag and clears it at that clock edge. If a wrap occurs at the same edge, the flag stays set.
- R8: Any write to select 2 forces the count to 0 and clears the wrap flag, with no interrupt pulse.
- R9: With a reload value of 0, the counter stays at 0 and never sets the flag.
- R10: With run enable 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_i | input | 2 | Register select |
| wr_en_i | input | 1 | Write strobe for the selected register |
| rd_en_i | input | 1 | Read strobe; on select 0 it clears the wrap flag |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | One-cycle interrupt pulse per completed period |

## Verification
The hardest case to reach from the ports is a flag-clearing read that lands on the same clock edge as a wrap. The bench first locks onto one interrupt pulse with a short reload in full-rate mode. It then counts core clocks to the edge of the next wrap and raises the read strobe exactly for that edge. The flag read afterwards must still be set, and the interrupt must have fired.

The period checks sweep several reload values in both rate modes. They measure the distance between interrupt pulses, so the free-running prescaler phase does not affect the result.

// File: rtl/tick_pkg.sv
`timescale 1ns/1ps
package tick_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_CURRENT = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  // control/status bit positions
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_IRQ_BIT  = 1;
  localparam int CTRL_RATE_BIT = 2;
  localparam int CTRL_FLAG_BIT = 16;

  typedef struct packed {
    logic run;
    logic irq_en;
    logic full_rate;
  } ctrl_t;

endpackage

// File: rtl/tick_prescaler.sv
`timescale 1ns/1ps
module tick_prescaler #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pulse_o
);

  generate
    if (DIV_LOG2 > 0) begin : g_div
      logic [DIV_LOG2-1:0] phase_q, phase_d;

      always_comb begin
        phase_d = phase_q + {{(DIV_LOG2-1){1'b0}}, 1'b1};
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) phase_q <= '0;
        else         phase_q <= phase_d;
      end

      assign pulse_o = &phase_q;

      // R4
      pulse_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);
    end else begin : g_nodiv
      logic unused_inputs;
      assign unused_inputs = clk_i ^ rst_ni;
      assign pulse_o = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/tick_regs.sv
`timescale 1ns/1ps
module tick_regs
  import tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        sel_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cur_wr_o,
  output logic              flag_clr_o,
  output logic [DATA_W-1:0] rdata_o
);

  reg_sel_e sel;
  ctrl_t ctrl_q, ctrl_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic ctrl_wr, reload_wr;
  logic unused_wdata;

  assign sel          = reg_sel_e'(sel_i);
  assign ctrl_wr      = wr_en_i && (sel == SEL_CTRL);
  assign reload_wr    = wr_en_i && (sel == SEL_RELOAD);
  assign cur_wr_o     = wr_en_i && (sel == SEL_CURRENT);
  assign flag_clr_o   = rd_en_i && (sel == SEL_CTRL);
  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.run       = wdata_i[CTRL_RUN_BIT];
      ctrl_d.irq_en    = wdata_i[CTRL_IRQ_BIT];
      ctrl_d.full_rate = wdata_i[CTRL_RATE_BIT];
    end
  end

  always_comb begin
    reload_d = reload_q;
    if (reload_wr) reload_d = wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_CTRL: begin
        rdata_o[CTRL_RUN_BIT]  = ctrl_q.run;
        rdata_o[CTRL_IRQ_BIT]  = ctrl_q.irq_en;
        rdata_o[CTRL_RATE_BIT] = ctrl_q.full_rate;
        rdata_o[CTRL_FLAG_BIT] = flag_i;
      end
      SEL_RELOAD:  rdata_o = DATA_W'(reload_q);
      SEL_CURRENT: rdata_o = DATA_W'(cnt_i);
      default:     rdata_o = '0;
    endcase
  end

  // R2
  reload_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_wr |=> reload_o == $past(wdata_i[CNT_W-1:0]));

endmodule

// File: rtl/tick_counter.sv
`timescale 1ns/1ps
module tick_counter
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic             pre_pulse_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             cur_wr_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             irq_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic flag_q, flag_d, irq_q, irq_d;
  logic tick, wrap;

  assign tick = ctrl_i.run && (ctrl_i.full_rate || pre_pulse_i);

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    irq_d  = 1'b0;
    wrap   = 1'b0;
    if (cur_wr_i) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else begin
      if (tick) begin
        if (cnt_q == '0) begin
          cnt_d = reload_i;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
          wrap  = (cnt_q == CNT_ONE);
        end
      end
      if (flag_clr_i) flag_d = 1'b0;
      if (wrap)       flag_d = 1'b1;
      irq_d = wrap && ctrl_i.irq_en;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  // R5
  reload_on_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_o == '0 && !cur_wr_i) |=> cnt_o == $past(reload_i));

  // R6
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && $past(ctrl_i.irq_en)));

  // R6
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R8
  cur_write_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_wr_i |=> (cnt_o == '0 && !flag_o && !irq_o));

  // R9
  zero_reload_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i == '0 && cnt_o == '0 && !cur_wr_i) |=> (cnt_o == '0 && !irq_o));

  // R10
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.run && !cur_wr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/tick_timer_top.sv
`timescale 1ns/1ps
module tick_timer_top
  import tick_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int DATA_W   = 32,
  parameter int DIV_LOG2 = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        sel_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  logic [1:0] rst_sync_q;
  logic rst_n_int;
  ctrl_t ctrl;
  logic [CNT_W-1:0] reload, cnt;
  logic cur_wr, flag_clr, flag, pre_pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  tick_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .pulse_o (pre_pulse)
  );

  tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .sel_i      (sel_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt),
    .flag_i     (flag),
    .ctrl_o     (ctrl),
    .reload_o   (reload),
    .cur_wr_o   (cur_wr),
    .flag_clr_o (flag_clr),
    .rdata_o    (rdata_o)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .ctrl_i      (ctrl),
    .pre_pulse_i (pre_pulse),
    .reload_i    (reload),
    .cur_wr_i    (cur_wr),
    .flag_clr_i  (flag_clr),
    .cnt_o       (cnt),
    .flag_o      (flag),
    .irq_o       (irq_o)
  );

endmodule

// File: tb/tick_timer_top_tb_top.sv
`timescale 1ns/1ps
module tick_timer_top_tb_top;

  localparam logic [1:0] S_CTRL = 2'd0;
  localparam logic [1:0] S_RLD  = 2'd1;
  localparam logic [1:0] S_CUR  = 2'd2;
  localparam logic [1:0] S_NONE = 2'd3;

  logic clk, rst_n, wr_en, rd_en, irq;
  logic [1:0] sel;
  logic [31:0] wdata, rdata;
  int checks, errors, cyc;

  tick_timer_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    sel = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    sel = s; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_irq(output int t);
    t = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq) begin t = cyc; break; end
    end
    if (t < 0) begin
      checks++; errors++;
      $display("FAIL R6: actual no interrupt expected interrupt pulse");
    end
  endtask

  task automatic run_period(input int r, input bit full);
    int t1, t2, t3, exp;
    bus_write(S_CTRL, 32'h0);
    bus_write(S_RLD, r);
    bus_write(S_CUR, 32'h0);
    bus_write(S_CTRL, full ? 32'h7 : 32'h3);
    wait_irq(t1); wait_irq(t2); wait_irq(t3);
    exp = (r + 1) * (full ? 1 : 8);
    if (full) begin
      chk("R3 period", t2 - t1, exp);
      chk("R3 period", t3 - t2, exp);
    end else begin
      chk("R4 period", t2 - t1, exp);
      chk("R4 period", t3 - t2, exp);
    end
    bus_write(S_CTRL, 32'h0);
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d, v0, v1, prev;
    int t;
    checks = 0; errors = 0;
    rst_n = 1'b0; sel = S_NONE; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(S_CTRL, d); chk("R1 ctrl", d, 32'h0);
    bus_read(S_RLD, d);  chk("R1 reload", d, 32'h0);
    bus_read(S_CUR, d);  chk("R1 current", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 register map
    bus_write(S_RLD, 32'hFFFF_FFFF);
    bus_read(S_RLD, d); chk("R2 reload width", d, 32'h00FF_FFFF);
    bus_write(S_RLD, 32'h0012_ABCD);
    bus_read(S_RLD, d); chk("R2 reload", d, 32'h0012_ABCD);
    bus_write(S_CTRL, 32'hFFFF_FFFA);
    bus_read(S_CTRL, d); chk("R2 ctrl bits", d, 32'h0000_0002);
    bus_write(S_NONE, 32'hFFFF_FFFF);
    bus_read(S_NONE, d); chk("R2 unmapped", d, 32'h0);
    bus_read(S_CTRL, d); chk("R2 unmapped write ignored", d, 32'h0000_0002);
    bus_write(S_CTRL, 32'h0);

    // R3 / R4 period sweeps
    for (int r = 1; r <= 6; r++) run_period(r, 1'b1);
    for (int r = 1; r <= 3; r++) run_period(r, 1'b0);

    // R5 step sequence, R6 flag without interrupt
    bus_write(S_CTRL, 32'h0);
    bus_write(S_RLD, 32'd3);
    bus_write(S_CUR, 32'h0);
    bus_read(S_CTRL, d);
    bus_write(S_CTRL, 32'h5);
    sel = S_CUR;
    #1 prev = rdata;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      #1 v0 = rdata;
      chk("R5 step", v0, (prev == 0) ? 32'd3 : prev - 1);
      chk("R6 irq gated", {31'b0, irq}, 32'h0);
      prev = v0;
    end
    bus_write(S_CTRL, 32'h0);
    bus_read(S_CTRL, d); chk("R6 flag set", d[16], 1'b1);
    bus_read(S_CTRL, d); chk("R7 flag cleared by read", d[16], 1'b0);

    // R7 read coinciding with wrap
    bus_write(S_RLD, 32'd3);
    bus_write(S_CUR, 32'h0);
    bus_write(S_CTRL, 32'h7);
    wait_irq(t);
    @(negedge clk); chk("R6 one-cycle pulse", {31'b0, irq}, 32'h0);
    @(negedge clk);
    @(negedge clk);
    sel = S_CTRL; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R7 irq at collision", {31'b0, irq}, 32'h1);
    #1 chk("R7 set wins over clear", rdata[16], 1'b1);

    // R8 current-value write
    wait_irq(t);
    bus_write(S_CUR, 32'h00AB_CDEF);
    sel = S_CUR;
    #1 chk("R8 count cleared", rdata, 32'h0);
    chk("R8 no irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 no irq after", {31'b0, irq}, 32'h0);
    sel = S_CTRL;
    #1 chk("R8 flag cleared", rdata[16], 1'b0);
    bus_write(S_CTRL, 32'h0);

    // R9 zero reload
    bus_write(S_RLD, 32'h0);
    bus_write(S_CUR, 32'h0);
    bus_write(S_CTRL, 32'h7);
    sel = S_CUR;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      #1 if (rdata !== 32'h0 || irq !== 1'b0) chk("R9 held at zero", {rdata[30:0], irq}, 32'h0);
    end
    chk("R9 count", rdata, 32'h0);
    bus_read(S_CTRL, d); chk("R9 no flag", d[16], 1'b0);
    bus_write(S_CTRL, 32'h0);

    // R10 stopped counter holds
    bus_write(S_RLD, 32'd100);
    bus_write(S_CTRL, 32'h5);
    repeat (10) @(negedge clk);
    bus_write(S_CTRL, 32'h1 << 2);
    bus_read(S_CUR, v0);
    repeat (20) @(negedge clk);
    bus_read(S_CUR, v1);
    chk("R10 hold", v1, v0);
    chk("R10 nonzero", {31'b0, (v0 != 0)}, 32'h1);

    report();
    $finish;
  end

endmodule